// File: doc/BRIEF.md
# Semaphore Acquire-Release Sequencer

This block sits between a local processor and one port of a hardware semaphore unit holding eight binary token flags. The processor issues a single command (acquire, release or initialise) with a flag index. The sequencer then produces the exact chain of access cycles that the semaphore port needs and reports one result code when it is finished. Flags are active low at the port: writing a 0 requests a token and writing a 1 gives it back. A read returns 0 when this side holds the token.

An acquire always writes the request first and reads the flag back in a separate, later cycle. If the read shows the token is held by the other side, a mode bit chooses between two policies. One withdraws the request at once by writing a 1. The other keeps polling with fresh reads, each separated by deselected cycles so that the port's latched read value can refresh. A programmable poll limit stops the polling: the request is then withdrawn and a timeout is reported. Release writes a 1 to one flag. Initialise writes a 1 to all eight flags in ascending order.

The controller is a single state machine. The states are IDLE, REQ_WR, SETTLE, TEST_RD, GAP, DROP, WITHDRAW, REL_WR, INIT_WR, INIT_GAP and FINISH.
- IDLE takes a command and goes to REQ_WR (acquire), REL_WR (release) or INIT_WR (initialise).
- REQ_WR goes to SETTLE, and SETTLE goes to TEST_RD.
- TEST_RD goes to FINISH when the read is 0. When the read is 1 it goes to DROP (withdraw mode, or the poll limit is used up) or to GAP (poll mode).
- GAP goes back to TEST_RD once its count expires.
- DROP goes to WITHDRAW, and WITHDRAW goes to FINISH.
- REL_WR goes to FINISH.
- INIT_WR goes to INIT_GAP, which goes back to INIT_WR, until the last index, where INIT_WR goes to FINISH.
- FINISH returns to IDLE.

Top module: `semtoken_seq`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, and sem_cs_n, sem_we_n and sem_oe_n are all 1.
- R2: An accepted acquire (cmd_op=2'b00) drives a write of 0 to cmd_idx in the cycle after acceptance (sem_cs_n=0, sem_we_n=0, sem_wdata=0). This is followed by exactly one deselected cycle and then a read of the same index (sem_cs_n=0, sem_we_n=1, sem_oe_n=0). During a write, sem_oe_n is 1.
- R3: If the read returns sem_rdata=0, the acquire ends with result 2'b00 (granted) and no further access.
- R4: With cmd_poll=0, a read of 1 is followed by one deselected cycle and a write of 1 to the same index. The acquire then ends with result 2'b01 (denied).
- R5: With cmd_poll=1, a read of 1 is followed by GAP_CYC deselected cycles and another read. sem_cs_n is never 0 on two consecutive cycles.
- R6: In poll mode, when max(cmd_limit,1) reads have all returned 1, the block deselects for one cycle, writes 1 to the index, and ends with result 2'b10 (timeout).
- R7: A release (cmd_op=2'b01) produces one write of 1 to cmd_idx and ends with result 2'b00.
- R8: An initialise (cmd_op=2'b10) writes 1 to indices 0 to 7 in ascending order, with one deselected cycle between writes, and ends with result 2'b00.
- R9: busy is 1 from the cycle after acceptance through the done cycle. done is a one-cycle pulse, and busy is 0 in the cycle after done.
- R10: A command presented while busy is ignored. Op code 2'b11 is ignored in idle and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 2 | 00 acquire, 01 release, 10 initialise, 11 no operation |
| cmd_idx | input | IDX_W | Semaphore flag index |
| cmd_poll | input | 1 | 1 = keep polling when denied, 0 = withdraw at once |
| cmd_limit | input | LIM_W | Maximum number of test reads in poll mode (0 acts as 1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 granted/ok, 01 denied, 10 timeout; valid with done |
| sem_cs_n | output | 1 | Semaphore port select, active low |
| sem_we_n | output | 1 | Semaphore port write strobe, active low (high = read) |
| sem_oe_n | output | 1 | Semaphore port output enable, active low |
| sem_addr | output | IDX_W | Semaphore flag address |
| sem_wdata | output | 1 | Data bit 0 written to the flag |
| sem_rdata | input | 1 | Data bit 0 read back from the flag |

## Verification
Acquire is tried in four situations against a bench model of the two-sided flag logic:
- a free flag, which must give an immediate grant;
- a flag held by the other side in withdraw mode, which must give a denial and a pending request that has been cleared;
- a held flag in poll mode that is freed part-way through, where the queued request turns into a grant;
- a flag held for the whole time, which must time out after exactly the limit number of reads, including a limit of 0.

Recording the ordered access trace, with cycle stamps, separates a correct write-then-read order and gap length from reordered or merged accesses. Release, initialise, commands sent while busy and the no-operation code are checked through the trace and the model's ownership.

// File: rtl/semtoken_pkg.sv
package semtoken_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ_WR,
        ST_SETTLE,
        ST_TEST_RD,
        ST_GAP,
        ST_DROP,
        ST_WITHDRAW,
        ST_REL_WR,
        ST_INIT_WR,
        ST_INIT_GAP,
        ST_FINISH
    } state_t;

    localparam logic [1:0] OP_ACQ  = 2'b00;
    localparam logic [1:0] OP_REL  = 2'b01;
    localparam logic [1:0] OP_INIT = 2'b10;
    localparam logic [1:0] OP_NOP  = 2'b11;

    localparam logic [1:0] RES_OK      = 2'b00;
    localparam logic [1:0] RES_DENIED  = 2'b01;
    localparam logic [1:0] RES_TIMEOUT = 2'b10;

endpackage

// File: rtl/semtoken_cnt.sv
module semtoken_cnt
    import semtoken_pkg::*;
#(
    parameter int NSEM    = 8,
    parameter int IDX_W   = 3,
    parameter int LIM_W   = 16,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  state_t           state,
    input  logic [LIM_W-1:0] lat_limit,
    output logic             gap_done,
    output logic             last_read,
    output logic             init_last,
    output logic [IDX_W-1:0] init_idx
);

    localparam int GAP_W = $clog2(GAP_CYC + 1);

    logic [LIM_W-1:0] rd_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic [LIM_W:0]   limit_eff;

    always_comb begin
        limit_eff = (lat_limit == '0) ? (LIM_W+1)'(1) : {1'b0, lat_limit};
    end

    // test reads issued in the current acquire
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            rd_cnt <= '0;
        end else if (state == ST_TEST_RD) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    // deselected cycles between poll reads
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_GAP) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // flag index walked by initialise
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            init_idx <= '0;
        end else if (state == ST_INIT_WR) begin
            init_idx <= init_idx + 1'b1;
        end
    end

    always_comb begin
        gap_done  = (gap_cnt == GAP_W'(GAP_CYC - 1));
        last_read = (({1'b0, rd_cnt} + (LIM_W+1)'(1)) >= limit_eff);
        init_last = (init_idx == IDX_W'(NSEM - 1));
    end

    AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEST_RD) |-> ({1'b0, rd_cnt} < limit_eff)); // R6

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (gap_cnt < GAP_W'(GAP_CYC))); // R5

endmodule

// File: rtl/semtoken_fsm.sv
module semtoken_fsm
    import semtoken_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             cmd_poll,
    input  logic [LIM_W-1:0] cmd_limit,
    input  logic             sem_rdata,
    input  logic             gap_done,
    input  logic             last_read,
    input  logic             init_last,
    output state_t           state,
    output logic [IDX_W-1:0] lat_idx,
    output logic [LIM_W-1:0] lat_limit,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result
);

    state_t     nxt;
    logic       lat_poll;
    logic [1:0] res_q;
    logic       accept;

    assign accept = (state == ST_IDLE) && cmd_valid && (cmd_op != OP_NOP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_op)
                        OP_ACQ:  nxt = ST_REQ_WR;
                        OP_REL:  nxt = ST_REL_WR;
                        default: nxt = ST_INIT_WR;
                    endcase
                end
            end
            ST_REQ_WR:   nxt = ST_SETTLE;
            ST_SETTLE:   nxt = ST_TEST_RD;
            ST_TEST_RD: begin
                if (!sem_rdata) begin
                    nxt = ST_FINISH;
                end else if (!lat_poll || last_read) begin
                    nxt = ST_DROP;
                end else begin
                    nxt = ST_GAP;
                end
            end
            ST_GAP:      nxt = gap_done ? ST_TEST_RD : ST_GAP;
            ST_DROP:     nxt = ST_WITHDRAW;
            ST_WITHDRAW: nxt = ST_FINISH;
            ST_REL_WR:   nxt = ST_FINISH;
            ST_INIT_WR:  nxt = init_last ? ST_FINISH : ST_INIT_GAP;
            ST_INIT_GAP: nxt = ST_INIT_WR;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // command fields and result code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx   <= '0;
            lat_limit <= '0;
            lat_poll  <= 1'b0;
            res_q     <= RES_OK;
        end else if (accept) begin
            lat_idx   <= cmd_idx;
            lat_limit <= cmd_limit;
            lat_poll  <= cmd_poll;
            res_q     <= RES_OK;
        end else if (state == ST_TEST_RD && sem_rdata) begin
            if (!lat_poll) begin
                res_q <= RES_DENIED;
            end else if (last_read) begin
                res_q <= RES_TIMEOUT;
            end
        end
    end

    // outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
        result = res_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(lat_idx)); // R10

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == OP_NOP) |=> !busy); // R10

endmodule

// File: rtl/semtoken_port.sv
module semtoken_port
    import semtoken_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  state_t           state,
    input  logic [IDX_W-1:0] lat_idx,
    input  logic [IDX_W-1:0] init_idx,
    output logic             sem_cs_n,
    output logic             sem_we_n,
    output logic             sem_oe_n,
    output logic [IDX_W-1:0] sem_addr,
    output logic             sem_wdata
);

    always_comb begin
        sem_cs_n  = 1'b1;
        sem_we_n  = 1'b1;
        sem_oe_n  = 1'b1;
        sem_addr  = lat_idx;
        sem_wdata = 1'b1;
        unique case (state)
            ST_REQ_WR: begin
                sem_cs_n  = 1'b0;
                sem_we_n  = 1'b0;
                sem_wdata = 1'b0;
            end
            ST_TEST_RD: begin
                sem_cs_n = 1'b0;
                sem_oe_n = 1'b0;
            end
            ST_WITHDRAW, ST_REL_WR: begin
                sem_cs_n = 1'b0;
                sem_we_n = 1'b0;
            end
            ST_INIT_WR: begin
                sem_cs_n = 1'b0;
                sem_we_n = 1'b0;
                sem_addr = init_idx;
            end
            default: begin
                sem_cs_n = 1'b1;
            end
        endcase
    end

    AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sem_cs_n |=> sem_cs_n); // R5

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sem_oe_n |-> (sem_we_n && !sem_cs_n)); // R2

endmodule

// File: rtl/semtoken_seq.sv
module semtoken_seq
    import semtoken_pkg::*;
#(
    parameter int NSEM    = 8,
    parameter int IDX_W   = $clog2(NSEM),
    parameter int LIM_W   = 16,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             cmd_poll,
    input  logic [LIM_W-1:0] cmd_limit,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    output logic             sem_cs_n,
    output logic             sem_we_n,
    output logic             sem_oe_n,
    output logic [IDX_W-1:0] sem_addr,
    output logic             sem_wdata,
    input  logic             sem_rdata
);

    state_t           state;
    logic [IDX_W-1:0] lat_idx;
    logic [IDX_W-1:0] init_idx;
    logic [LIM_W-1:0] lat_limit;
    logic             gap_done;
    logic             last_read;
    logic             init_last;

    semtoken_fsm #(.IDX_W(IDX_W), .LIM_W(LIM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_poll  (cmd_poll),
        .cmd_limit (cmd_limit),
        .sem_rdata (sem_rdata),
        .gap_done  (gap_done),
        .last_read (last_read),
        .init_last (init_last),
        .state     (state),
        .lat_idx   (lat_idx),
        .lat_limit (lat_limit),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    semtoken_cnt #(.NSEM(NSEM), .IDX_W(IDX_W), .LIM_W(LIM_W), .GAP_CYC(GAP_CYC)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_limit (lat_limit),
        .gap_done  (gap_done),
        .last_read (last_read),
        .init_last (init_last),
        .init_idx  (init_idx)
    );

    semtoken_port #(.IDX_W(IDX_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_idx   (lat_idx),
        .init_idx  (init_idx),
        .sem_cs_n  (sem_cs_n),
        .sem_we_n  (sem_we_n),
        .sem_oe_n  (sem_oe_n),
        .sem_addr  (sem_addr),
        .sem_wdata (sem_wdata)
    );

    AST_ACQ_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_ACQ)
        |=> (!sem_cs_n && !sem_we_n && !sem_wdata && sem_addr == $past(cmd_idx))); // R2

    AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11)); // R3

endmodule

// File: tb/semtoken_seq_tb_top.sv
`timescale 1ns/1ps
module semtoken_seq_tb_top;

    localparam int NSEM  = 8;
    localparam int IDX_W = 3;
    localparam int LIM_W = 16;
    localparam int GAP   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [IDX_W-1:0] cmd_idx = '0;
    logic             cmd_poll = 1'b0;
    logic [LIM_W-1:0] cmd_limit = '0;
    logic             busy, done, sem_cs_n, sem_we_n, sem_oe_n, sem_wdata, sem_rdata;
    logic [1:0]       result;
    logic [IDX_W-1:0] sem_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    semtoken_seq #(.NSEM(NSEM), .LIM_W(LIM_W), .GAP_CYC(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_poll(cmd_poll), .cmd_limit(cmd_limit),
        .busy(busy), .done(done), .result(result), .sem_cs_n(sem_cs_n),
        .sem_we_n(sem_we_n), .sem_oe_n(sem_oe_n), .sem_addr(sem_addr),
        .sem_wdata(sem_wdata), .sem_rdata(sem_rdata)
    );

    // two-sided flag model: own 0 free, 1 this side, 2 other side
    int       own [NSEM];
    bit       ra  [NSEM];
    bit       rb  [NSEM];
    logic     b_en = 1'b0;
    logic [2:0] b_idx = '0;
    logic     b_val = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEM; i++) begin
                own[i] <= 0; ra[i] <= 1'b1; rb[i] <= 1'b1;
            end
        end else begin
            if (!sem_cs_n && !sem_we_n) begin
                ra[sem_addr] <= sem_wdata;
                if (!sem_wdata && own[sem_addr] == 0) own[sem_addr] <= 1;
                if (sem_wdata && own[sem_addr] == 1) own[sem_addr] <= (rb[sem_addr] == 1'b0) ? 2 : 0;
            end
            if (b_en) begin
                rb[b_idx] <= b_val;
                if (!b_val && own[b_idx] == 0) own[b_idx] <= 2;
                if (b_val && own[b_idx] == 2) own[b_idx] <= (ra[b_idx] == 1'b0) ? 1 : 0;
            end
        end
    end

    assign sem_rdata = (!sem_cs_n && sem_we_n && !sem_oe_n) ? ((own[sem_addr] == 1) ? 1'b0 : 1'b1) : 1'b1;

    // access trace: kind 0 = write 0, 1 = write 1, 2 = read
    int   tr_kind [32];
    int   tr_addr [32];
    int   tr_cyc  [32];
    int   tr_n = 0;
    int   consec_bad = 0;
    logic tr_clr = 1'b0;
    logic prev_sel = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_sel <= rst_n && !sem_cs_n;
        if (rst_n && !sem_cs_n && prev_sel) consec_bad <= consec_bad + 1;
        if (tr_clr) begin
            tr_n <= 0;
        end else if (rst_n && !sem_cs_n && tr_n < 32) begin
            tr_kind[tr_n] <= !sem_we_n ? (sem_wdata ? 1 : 0) : 2;
            tr_addr[tr_n] <= int'(sem_addr);
            tr_cyc[tr_n]  <= cyc;
            tr_n <= tr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_trace();
        tr_clr = 1'b1;
        @(negedge clk);
        tr_clr = 1'b0;
    endtask

    task automatic b_write(input int idx, input bit val);
        b_en = 1'b1; b_idx = 3'(idx); b_val = val;
        @(negedge clk);
        b_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input int idx, input bit poll, input int lim);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = 3'(idx);
        cmd_poll = poll; cmd_limit = 16'(lim);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    endtask

    task automatic wait_done(input int exp_res, input string req);
        int n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done seen", int'(done), 1);
        chk(int'(result) == exp_res, req, int'(result), exp_res);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 idle after done", int'({busy, done}), 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
        chk({sem_cs_n, sem_we_n, sem_oe_n} == 3'b111, "R1 port idle", int'({sem_cs_n, sem_we_n, sem_oe_n}), 7);
    endtask

    task automatic t_grant_release();
        clear_trace();
        issue(2'b00, 2, 1'b0, 4);
        wait_done(0, "R3 grant result");
        chk(own[2] == 1, "R3 owner", own[2], 1);
        chk(tr_n == 2, "R3 access count", tr_n, 2);
        chk(tr_kind[0] == 0 && tr_addr[0] == 2, "R2 first access write0", tr_kind[0], 0);
        chk(tr_kind[1] == 2 && tr_addr[1] == 2, "R2 then read", tr_kind[1], 2);
        chk(tr_cyc[1] - tr_cyc[0] == 2, "R2 one deselect cycle", tr_cyc[1] - tr_cyc[0], 2);
        clear_trace();
        issue(2'b01, 2, 1'b0, 0);
        wait_done(0, "R7 release result");
        chk(tr_n == 1 && tr_kind[0] == 1 && tr_addr[0] == 2, "R7 single write1", tr_n, 1);
        chk(own[2] == 0, "R7 flag free", own[2], 0);
    endtask

    task automatic t_deny();
        b_write(4, 1'b0);
        clear_trace();
        issue(2'b00, 4, 1'b0, 9);
        wait_done(1, "R4 denied result");
        chk(tr_n == 3 && tr_kind[2] == 1 && tr_addr[2] == 4, "R4 withdraw write1", tr_n, 3);
        chk(tr_cyc[2] - tr_cyc[1] == 2, "R4 deselect before withdraw", tr_cyc[2] - tr_cyc[1], 2);
        chk(own[4] == 2 && ra[4] == 1'b1, "R4 request withdrawn", own[4], 2);
        b_write(4, 1'b1);
        chk(own[4] == 0, "R4 no later grab", own[4], 0);
    endtask

    task automatic t_timeout();
        b_write(5, 1'b0);
        clear_trace();
        issue(2'b00, 5, 1'b1, 3);
        repeat (3) @(negedge clk);
        // R10: release offered while busy must be dropped
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_idx = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(2, "R6 timeout result");
        chk(tr_n == 5, "R6 W0 + 3 reads + W1", tr_n, 5);
        chk(tr_kind[1] == 2 && tr_kind[2] == 2 && tr_kind[3] == 2, "R6 three reads", tr_kind[3], 2);
        chk(tr_kind[4] == 1 && tr_addr[4] == 5, "R6 withdraw write1", tr_kind[4], 1);
        chk(tr_cyc[2] - tr_cyc[1] == GAP + 1, "R5 poll spacing", tr_cyc[2] - tr_cyc[1], GAP + 1);
        chk(tr_cyc[3] - tr_cyc[2] == GAP + 1, "R5 poll spacing 2", tr_cyc[3] - tr_cyc[2], GAP + 1);
        chk(own[5] == 2 && ra[5] == 1'b1, "R10 busy command ignored", own[5], 2);
        b_write(5, 1'b1);
    endtask

    task automatic t_limit0();
        b_write(6, 1'b0);
        clear_trace();
        issue(2'b00, 6, 1'b1, 0);
        wait_done(2, "R6 limit zero timeout");
        chk(tr_n == 3, "R6 limit zero single read", tr_n, 3);
        b_write(6, 1'b1);
    endtask

    task automatic t_poll_win();
        int n = 0;
        b_write(1, 1'b0);
        clear_trace();
        issue(2'b00, 1, 1'b1, 20);
        while (tr_n < 3 && n < 100) begin
            @(negedge clk);
            n++;
        end
        b_write(1, 1'b1);
        wait_done(0, "R5 poll grant result");
        chk(own[1] == 1, "R5 poll owner", own[1], 1);
        chk(tr_kind[tr_n - 1] == 2, "R5 ends with read", tr_kind[tr_n - 1], 2);
        chk(consec_bad == 0, "R5 no back-to-back select", consec_bad, 0);
        issue(2'b01, 1, 1'b0, 0);
        wait_done(0, "R7 release after poll");
    endtask

    task automatic t_init();
        issue(2'b00, 7, 1'b0, 1);
        wait_done(0, "R3 grant before init");
        clear_trace();
        issue(2'b10, 0, 1'b0, 0);
        wait_done(0, "R8 init result");
        chk(tr_n == 8, "R8 eight writes", tr_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk(tr_kind[i] == 1 && tr_addr[i] == i, "R8 ascending write1", tr_addr[i], i);
            if (i > 0) chk(tr_cyc[i] - tr_cyc[i-1] == 2, "R8 deselect between", tr_cyc[i] - tr_cyc[i-1], 2);
        end
        chk(own[7] == 0, "R8 flag freed", own[7], 0);
    endtask

    task automatic t_nop();
        clear_trace();
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_idx = 3'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R10 nop not accepted", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(tr_n == 0, "R10 nop no access", tr_n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_release();
        t_deny();
        t_timeout();
        t_limit0();
        t_poll_win();
        t_init();
        t_nop();
        chk(consec_bad == 0, "R5 select never held", consec_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule